// File: doc/BRIEF.md
# Keyboard Receiver Register Block

This block is a bus slave that sits between a keyboard-side character source and a processor. Each time the keyboard side pulses a strobe with an 8-bit character, the block stores the character and raises a ready flag. The processor sees two 32-bit words on a simple word bus: a control/status word and a data word. The control word shows the ready flag and a writable interrupt enable. The data word returns the most recent character.

Reading the data word has a side effect: it clears the ready flag. The interrupt request is a level. It is high while the ready flag and the interrupt enable are both set, and it is meant to be wired to hardware interrupt line 1. Only one character is held. A new arrival replaces the stored character. When an arrival and a data read fall in the same cycle, the arrival wins.

The bus read path is combinational: `rd_data` is valid in the same cycle as `rd_en` and `addr`. State changes caused by a read or a write take effect at the next rising clock edge.

Top module: `kbd_rx_regs`

## Requirements
- R1: The control word is at byte address 0xFFFF0000 and the data word at 0xFFFF0004. Any other address, including misaligned ones, reads as 0, and writes to it change nothing.
- R2: After reset the control word reads 0, the data word reads 0, and `irq` is low.
- R3: A cycle with `key_vld` high stores `key_char` and sets the ready flag (control bit 0) from the next clock edge on.
- R4: A bus read of the data word clears the ready flag at the next edge. A read of the control word leaves the ready flag unchanged.
- R5: Control bit 0 is read-only: bus writes do not change it. Control bits 31:2 always read 0.
- R6: Control bit 1 is the interrupt enable. A write to the control word loads it from `wr_data[1]`, and a read returns it.
- R7: The data word returns the stored character in bits 7:0, with bits 31:8 reading 0. Bus writes to it are ignored, and the stored character changes only on `key_vld`.
- R8: `irq` is high exactly when both the ready flag and the interrupt enable are 1. It therefore drops after a data read or after the enable is cleared.
- R9: An arrival while the ready flag is already set overwrites the stored character, and the ready flag stays 1.
- R10: When an arrival and a data read occur in the same cycle, the read returns the old character. The new character is stored and the ready flag ends at 1.
- R11: When `rd_en` is low, `rd_data` is 0 and no side effect takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 32 | Byte address of the bus access |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 32 | Bus read data (combinational) |
| key_vld | input | 1 | One-cycle character arrival strobe |
| key_char | input | 8 | Arriving character |
| irq | output | 1 | Level interrupt request (ready AND enable) |

## Verification
The assertions assume that `key_vld`, `key_char` and all bus signals are synchronous to `clk`. They also assume that a single bus access does not carry `rd_en` and `wr_en` together. The bench meets both assumptions: it changes every input just after a falling edge and issues reads and writes in separate tasks. The bench deliberately raises `key_vld` in the same cycle as a data read to exercise the arrival-wins ordering, which is a legal overlap. Before checking a word, the bench brings the internal flags out through control-word reads, which have no side effect.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } kbd_sel_e;

  localparam int RDY_BIT = 0;
  localparam int IEN_BIT = 1;
endpackage

// File: rtl/kbd_rx_rst_sync.sv
module kbd_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/kbd_rx_decode.sv
module kbd_rx_decode
  import kbd_rx_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'hFFFF_0000,
  parameter logic [31:0] DATA_ADDR = 32'hFFFF_0004
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output kbd_sel_e          sel,
  output logic              ctrl_wr,
  output logic              data_rd
);
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] DATA_A = DATA_ADDR[ADDR_W-1:0];

  always_comb begin
    if (addr == CTRL_A)      sel = SEL_CTRL;
    else if (addr == DATA_A) sel = SEL_DATA;
    else                     sel = SEL_NONE;
  end

  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign data_rd = rd_en && (sel == SEL_DATA);
endmodule

// File: rtl/kbd_rx_state.sv
module kbd_rx_state #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              ctrl_wr,
  input  logic              wr_ien,
  input  logic              data_rd,
  output logic              ready,
  output logic              ien,
  output logic [CHAR_W-1:0] char_q
);
  logic              ready_q, ready_d;
  logic              ien_q, ien_d;
  logic [CHAR_W-1:0] char_d;
  logic              char_en;
  logic              ien_en;

  // Next-state logic with explicit enables
  always_comb begin
    char_en = key_vld;
    ien_en  = ctrl_wr;
    char_d  = key_char;
    ien_d   = wr_ien;
    // arrival has priority over the clearing read
    if (key_vld)      ready_d = 1'b1;
    else if (data_rd) ready_d = 1'b0;
    else              ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ien_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      if (ien_en)  ien_q  <= ien_d;
      if (char_en) char_q <= char_d;
    end
  end

  assign ready = ready_q;
  assign ien   = ien_q;

  // R3
  arrive_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |=> ready_q);
  // R4
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_vld) |=> !ready_q);
  // R9
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !data_rd) |=> ready_q);
  // R7
  char_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> $stable(char_q));
  // R6
  ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ien_q == $past(wr_ien)));
  // R6
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ien_q));
endmodule

// File: rtl/kbd_rx_rdmux.sv
module kbd_rx_rdmux
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  kbd_sel_e          sel,
  input  logic              rd_en,
  input  logic              ready,
  input  logic              ien,
  input  logic [CHAR_W-1:0] char_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_CTRL: begin
          rd_data[RDY_BIT] = ready;
          rd_data[IEN_BIT] = ien;
        end
        SEL_DATA: rd_data[CHAR_W-1:0] = char_q;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/kbd_rx_regs.sv
module kbd_rx_regs
  import kbd_rx_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          CHAR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] CTRL_ADDR   = 32'hFFFF_0000,
  parameter logic [31:0] DATA_ADDR   = 32'hFFFF_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              key_vld,
  input  logic [CHAR_W-1:0] key_char,
  output logic              irq
);
  logic     rst_n_s;
  kbd_sel_e sel;
  logic     ctrl_wr;
  logic     data_rd;
  logic     ready;
  logic     ien;
  logic [CHAR_W-1:0] char_q;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DATA_W-1:IEN_BIT+1], wr_data[RDY_BIT]};

  kbd_rx_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  kbd_rx_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) decode_i (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .sel(sel), .ctrl_wr(ctrl_wr), .data_rd(data_rd)
  );

  kbd_rx_state #(.CHAR_W(CHAR_W)) state_i (
    .clk(clk), .rst_n(rst_n_s),
    .key_vld(key_vld), .key_char(key_char),
    .ctrl_wr(ctrl_wr), .wr_ien(wr_data[IEN_BIT]), .data_rd(data_rd),
    .ready(ready), .ien(ien), .char_q(char_q)
  );

  kbd_rx_rdmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) rdmux_i (
    .sel(sel), .rd_en(rd_en), .ready(ready), .ien(ien), .char_q(char_q),
    .rd_data(rd_data)
  );

  assign irq = ready & ien;

  // R8
  irq_drop_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (data_rd && !key_vld) |=> !irq);
  // R8
  irq_rise_on_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (key_vld && ien && !ctrl_wr) |=> irq);
  // R5
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr == CTRL_ADDR[ADDR_W-1:0]) |-> (rd_data[DATA_W-1:IEN_BIT+1] == '0));
  // R7
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr == DATA_ADDR[ADDR_W-1:0]) |-> (rd_data[DATA_W-1:CHAR_W] == '0));
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (addr != CTRL_ADDR[ADDR_W-1:0] && addr != DATA_ADDR[ADDR_W-1:0]) |-> (rd_data == '0));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/kbd_rx_regs_tb_top.sv
`timescale 1ns/1ps
module kbd_rx_regs_tb_top;
  localparam logic [31:0] A_CTRL = 32'hFFFF_0000;
  localparam logic [31:0] A_DATA = 32'hFFFF_0004;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        key_vld;
  logic [7:0]  key_char;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  kbd_rx_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .key_vld(key_vld), .key_char(key_char),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic type_key(input logic [7:0] c);
    @(negedge clk);
    key_vld = 1'b1; key_char = c;
    @(negedge clk);
    key_vld = 1'b0; key_char = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1 check("R2 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(A_CTRL, d); check("R2 ctrl after reset", d, 32'd0);
    bus_read(A_DATA, d); check("R2 data after reset", d, 32'd0);
  endtask

  task automatic t_arrive();
    logic [31:0] d;
    type_key(8'h41);
    bus_read(A_CTRL, d); check("R3 ready set", d, 32'd1);
    bus_read(A_CTRL, d); check("R4 ctrl read keeps ready", d, 32'd1);
    bus_read(A_DATA, d); check("R3 char stored", d, 32'h41);
    bus_read(A_CTRL, d); check("R4 data read clears ready", d, 32'd0);
  endtask

  task automatic t_ready_ro();
    logic [31:0] d;
    type_key(8'h42);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, d); check("R5 write 0 keeps ready", d, 32'd1);
    bus_write(A_CTRL, 32'hFFFF_FFFC);
    bus_read(A_CTRL, d); check("R5 upper bits read 0", d, 32'd1);
    bus_read(A_DATA, d);
    bus_write(A_CTRL, 32'h1);
    bus_read(A_CTRL, d); check("R5 write 1 cannot set ready", d, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(A_CTRL, 32'h2);
    bus_read(A_CTRL, d); check("R6 enable reads back", d, 32'd2);
    #1 check("R8 irq low without ready", {31'd0, irq}, 32'd0);
    type_key(8'h55);
    #1 check("R8 irq high", {31'd0, irq}, 32'd1);
    bus_read(A_DATA, d);
    #1 check("R8 irq drops after data read", {31'd0, irq}, 32'd0);
    type_key(8'h56);
    #1 check("R8 irq high again", {31'd0, irq}, 32'd1);
    bus_write(A_CTRL, 32'h0);
    #1 check("R8 irq drops on disable", {31'd0, irq}, 32'd0);
    bus_read(A_CTRL, d); check("R6 enable cleared, ready kept", d, 32'd1);
    bus_read(A_DATA, d);
  endtask

  task automatic t_data_ro();
    logic [31:0] d;
    type_key(8'hFF);
    bus_read(A_DATA, d); check("R7 upper bits zero", d, 32'h0000_00FF);
    bus_write(A_DATA, 32'h1234_5610);
    bus_read(A_DATA, d); check("R7 write to data ignored", d, 32'h0000_00FF);
    bus_read(A_CTRL, d); check("R7 write to data leaves ready", d, 32'd0);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    type_key(8'h11);
    type_key(8'h22);
    bus_read(A_CTRL, d); check("R9 ready stays set", d, 32'd1);
    bus_read(A_DATA, d); check("R9 newest char kept", d, 32'h22);
    bus_read(A_CTRL, d); check("R9 ready cleared after read", d, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    type_key(8'h33);
    @(negedge clk);
    addr = A_DATA; rd_en = 1'b1; key_vld = 1'b1; key_char = 8'h44;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; addr = '0; key_vld = 1'b0; key_char = '0;
    check("R10 read returns old char", d, 32'h33);
    bus_read(A_CTRL, d); check("R10 arrival wins ready", d, 32'd1);
    bus_read(A_DATA, d); check("R10 new char stored", d, 32'h44);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(32'hFFFF_0008, 32'h2);
    bus_write(32'hFFFF_0001, 32'h2);
    bus_read(A_CTRL, d); check("R1 other addresses ignore writes", d, 32'd0);
    type_key(8'h77);
    bus_read(32'hFFFF_0008, d); check("R1 unmapped reads 0", d, 32'd0);
    bus_read(32'hFFFF_0005, d); check("R1 misaligned reads 0", d, 32'd0);
    @(negedge clk);
    addr = A_DATA; rd_en = 1'b0;
    #1 d = rd_data;
    @(negedge clk);
    addr = '0;
    check("R11 idle read data zero", d, 32'd0);
    bus_read(A_CTRL, d); check("R11 no side effect without rd_en", d, 32'd1);
    bus_read(A_DATA, d); check("R1 data address", d, 32'h77);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    key_vld = 1'b0; key_char = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_arrive();
    t_ready_ro();
    t_irq();
    t_data_ro();
    t_overwrite();
    t_collide();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule